// File: doc/BRIEF.md
# Serial-Loaded Channel Enable Register

This block produces the eight switch enables of a four-phase unipolar motor driver: a plus and a minus enable per phase. In serial mode a host shifts an 8-bit word in over a data line and a serial clock, then pulses a latch strobe. The strobe copies the word into a storage register whose bits drive the enables. A gate input applies or suppresses all stored enables together. An active-low clear empties the storage register. An active-low standby input forces every enable off in either mode. In parallel mode each of eight input pins drives one enable directly.

All host-side inputs are asynchronous to the block clock. They pass through a synchronizer chain. The serial clock and the latch strobe are turned into single-cycle rising-edge pulses. A four-state output machine picks the source of the enables from the synchronized standby, mode and gate levels. The states are `OUT_STANDBY` (all off), `OUT_PARALLEL` (enables follow the pins), `OUT_MUTED` (serial mode, gate low, all off) and `OUT_DRIVE` (serial mode, stored bits applied). Every clock the machine moves to the state set by a fixed priority: standby low goes to `OUT_STANDBY`; otherwise mode low goes to `OUT_PARALLEL`; otherwise gate low goes to `OUT_MUTED`; otherwise the machine goes to `OUT_DRIVE`. Any state can reach any other in one step.

Top module: `chan_enable_ser`

## Requirements
- R1: After reset `en_out` is 0 and the output machine is in `OUT_STANDBY`.
- R2: On each rising serial clock while clear is high, shift stage 0 takes `ser_data` and stage k takes the old stage k-1. After eight clocks the first bit sent sits in stage 7 and the last bit sent sits in stage 0.
- R3: The shift register does not change on a falling serial clock, nor on a rising serial clock while clear is low.
- R4: A rising latch edge while clear is high copies the shift register into storage. At all other times with clear high, storage holds its value, including across a falling latch edge and across serial clocks.
- R5: While `ser_clr_n` is low the storage register is 0, even when a latch edge arrives at the same time. The shift register is not changed by clear.
- R6: Storage stage k drives `en_out[k]`. Bits 0..7 are phase A plus, A minus, B plus, B minus, C plus, C minus, D plus, D minus. A word sent most-significant bit first and then latched therefore appears on `en_out` as the same word.
- R7: In serial mode with standby high, `gate_en` low gives `en_out` = 0, and `gate_en` high gives `en_out` = storage.
- R8: `stby_n` low gives `en_out` = 0 in both modes. The storage contents survive standby and reappear when standby is released.
- R9: With standby high and `mode_serial` low, `en_out` equals `par_in` bit for bit, and `gate_en` has no effect. Serial loading and latching still update storage, and the new value shows once serial mode is selected.
- R10: A change on any input is visible at `en_out` within four block clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_serial | input | 1 | 1 selects serial path, 0 selects parallel pins |
| ser_clk | input | 1 | Serial shift clock, shifts on its rising edge |
| ser_data | input | 1 | Serial data bit |
| ser_clr_n | input | 1 | Active-low clear of the storage register |
| ser_latch | input | 1 | Latch strobe, copies on its rising edge |
| gate_en | input | 1 | 1 applies stored enables in serial mode |
| stby_n | input | 1 | Active-low standby, forces all enables off |
| par_in | input | 2*PHASES | Direct enables in parallel mode |
| en_out | output | 2*PHASES | Switch enables, bit 2p plus and bit 2p+1 minus of phase p |

## Verification
Two functions can fall in the same cycle: the clear and a latch edge, both acting on the storage register. The bench pulses the latch while `ser_clr_n` is held low. It checks that the enables stay at 0. It then raises clear and latches again to show that the shift contents survived. The bench also loads and latches a word while the block is in parallel mode, and then confirms that the word appears only after the switch to serial mode.

// File: rtl/chan_en_pkg.sv
package chan_en_pkg;

    typedef enum logic [1:0] {
        OUT_STANDBY  = 2'd0,
        OUT_PARALLEL = 2'd1,
        OUT_MUTED    = 2'd2,
        OUT_DRIVE    = 2'd3
    } out_state_t;

endpackage

// File: rtl/chan_en_sync.sv
module chan_en_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/chan_en_edge.sv
module chan_en_edge #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise
);

    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= lvl;
        end
    end

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            assign rise[b] = lvl[b] & ~prev_q[b];
        end
    endgenerate

endmodule

// File: rtl/chan_en_shift_store.sv
module chan_en_shift_store #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_n,
    input  logic            sdata,
    input  logic            shift_stb,
    input  logic            load_stb,
    output logic [BITS-1:0] shift_q,
    output logic [BITS-1:0] store_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (shift_stb && clr_n) begin
            shift_q <= {shift_q[BITS-2:0], sdata};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= '0;
        end else if (!clr_n) begin
            store_q <= '0;
        end else if (load_stb) begin
            store_q <= shift_q;
        end
    end

endmodule

// File: rtl/chan_en_out_fsm.sv
module chan_en_out_fsm
    import chan_en_pkg::*;
#(
    parameter int PHASES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stby_n,
    input  logic                  mode_ser,
    input  logic                  gate,
    input  logic [2*PHASES-1:0]   par,
    input  logic [2*PHASES-1:0]   stored,
    output logic [2*PHASES-1:0]   en
);

    localparam int EN_BITS = 2 * PHASES;

    out_state_t state_q;
    out_state_t state_d;
    logic [EN_BITS-1:0] sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OUT_STANDBY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_STANDBY, OUT_PARALLEL, OUT_MUTED, OUT_DRIVE: begin
                if (!stby_n) begin
                    state_d = OUT_STANDBY;
                end else if (!mode_ser) begin
                    state_d = OUT_PARALLEL;
                end else if (!gate) begin
                    state_d = OUT_MUTED;
                end else begin
                    state_d = OUT_DRIVE;
                end
            end
            default: state_d = OUT_STANDBY;
        endcase
    end

    always_comb begin
        unique case (state_q)
            OUT_STANDBY:  sel = '0;
            OUT_PARALLEL: sel = par;
            OUT_MUTED:    sel = '0;
            OUT_DRIVE:    sel = stored;
            default:      sel = '0;
        endcase
    end

    generate
        for (genvar p = 0; p < PHASES; p++) begin : g_phase
            assign en[2*p]   = sel[2*p];
            assign en[2*p+1] = sel[2*p+1];
        end
    endgenerate

endmodule

// File: rtl/chan_enable_ser.sv
module chan_enable_ser
    import chan_en_pkg::*;
#(
    parameter int PHASES      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_serial,
    input  logic                ser_clk,
    input  logic                ser_data,
    input  logic                ser_clr_n,
    input  logic                ser_latch,
    input  logic                gate_en,
    input  logic                stby_n,
    input  logic [2*PHASES-1:0] par_in,
    output logic [2*PHASES-1:0] en_out
);

    localparam int EN_BITS  = 2 * PHASES;
    localparam int CTL_BITS = 7;
    localparam int SYNC_W   = EN_BITS + CTL_BITS;

    logic [SYNC_W-1:0]  raw_in;
    logic [SYNC_W-1:0]  synced;
    logic               sclk_s, data_s, clr_s, latch_s, gate_s, stby_s, mode_s;
    logic [EN_BITS-1:0] par_s;
    logic               clk_rise, latch_rise;
    logic [EN_BITS-1:0] shift_q, store_q;

    assign raw_in = {par_in, mode_serial, stby_n, gate_en,
                     ser_latch, ser_clr_n, ser_data, ser_clk};

    chan_en_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (synced)
    );

    assign sclk_s  = synced[0];
    assign data_s  = synced[1];
    assign clr_s   = synced[2];
    assign latch_s = synced[3];
    assign gate_s  = synced[4];
    assign stby_s  = synced[5];
    assign mode_s  = synced[6];
    assign par_s   = synced[SYNC_W-1:CTL_BITS];

    chan_en_edge #(.WIDTH(2)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  ({latch_s, sclk_s}),
        .rise ({latch_rise, clk_rise})
    );

    chan_en_shift_store #(.BITS(EN_BITS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (clr_s),
        .sdata    (data_s),
        .shift_stb(clk_rise),
        .load_stb (latch_rise),
        .shift_q  (shift_q),
        .store_q  (store_q)
    );

    chan_en_out_fsm #(.PHASES(PHASES)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .stby_n  (stby_s),
        .mode_ser(mode_s),
        .gate    (gate_s),
        .par     (par_s),
        .stored  (store_q),
        .en      (en_out)
    );

endmodule

module chan_en_chk #(
    parameter int EN_BITS = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               stby_s,
    input logic               mode_s,
    input logic               gate_s,
    input logic               clr_s,
    input logic               data_s,
    input logic               clk_rise,
    input logic               latch_rise,
    input logic [EN_BITS-1:0] par_s,
    input logic [EN_BITS-1:0] shift_q,
    input logic [EN_BITS-1:0] store_q,
    input logic [EN_BITS-1:0] en_out
);

    // R2: a synchronized rising serial clock shifts data into stage 0
    a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_rise && clr_s) |=> shift_q == {$past(shift_q[EN_BITS-2:0]), $past(data_s)});

    // R3: without a qualified rising serial clock the shift register holds
    a_r3_hold_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !(clk_rise && clr_s) |=> $stable(shift_q));

    // R4: a qualified latch edge copies the shift register
    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_rise && clr_s) |=> store_q == $past(shift_q));

    // R4: no latch edge with clear high keeps storage
    a_r4_hold_store: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_rise && clr_s) |=> $stable(store_q));

    // R5: clear low empties storage even against a latch edge
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_s |=> store_q == '0);

    // R7: gate low in serial mode turns all enables off
    a_r7_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        (stby_s && mode_s && !gate_s) |=> en_out == '0);

    // R8: standby forces all enables off
    a_r8_standby_off: assert property (@(posedge clk) disable iff (!rst_n)
        !stby_s |=> en_out == '0);

    // R9: parallel mode passes the pins through
    a_r9_parallel: assert property (@(posedge clk) disable iff (!rst_n)
        (stby_s && !mode_s) |=> en_out == par_s);

endmodule

bind chan_enable_ser chan_en_chk #(.EN_BITS(EN_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stby_s    (stby_s),
    .mode_s    (mode_s),
    .gate_s    (gate_s),
    .clr_s     (clr_s),
    .data_s    (data_s),
    .clk_rise  (clk_rise),
    .latch_rise(latch_rise),
    .par_s     (par_s),
    .shift_q   (shift_q),
    .store_q   (store_q),
    .en_out    (en_out)
);

// File: tb/tb_chan_enable_ser.sv
`timescale 1ns/1ps
module tb_chan_enable_ser;

    localparam int PHASES = 4;
    localparam int EB     = 2 * PHASES;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          mode_serial, ser_clk, ser_data, ser_clr_n, ser_latch, gate_en, stby_n;
    logic [EB-1:0] par_in;
    logic [EB-1:0] en_out;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    logic [EB-1:0] mdl_shift = '0;
    logic [EB-1:0] mdl_store = '0;

    always #10 clk = ~clk;

    chan_enable_ser #(.PHASES(PHASES)) dut (
        .clk(clk), .rst_n(rst_n), .mode_serial(mode_serial), .ser_clk(ser_clk),
        .ser_data(ser_data), .ser_clr_n(ser_clr_n), .ser_latch(ser_latch),
        .gate_en(gate_en), .stby_n(stby_n), .par_in(par_in), .en_out(en_out)
    );

    function automatic logic [EB-1:0] exp_en(input logic sb, input logic md,
                                             input logic gt, input logic [EB-1:0] pr,
                                             input logic [EB-1:0] st);
        if (!sb)      return '0;
        else if (!md) return pr;
        else if (!gt) return '0;
        else          return st;
    endfunction

    task automatic check(input string req, input logic [EB-1:0] expv);
        n_checks++;
        if (en_out !== expv) begin
            n_fails++;
            $display("FAIL %s: en_out=%02h expected=%02h at %0t", req, en_out, expv, $time);
        end
    endtask

    task automatic check_model(input string req);
        check(req, exp_en(stby_n, mode_serial, gate_en, par_in, mdl_store));
    endtask

    task automatic send_bit(input logic b);
        ser_data = b;
        #100;
        ser_clk = 1'b1;
        if (ser_clr_n) mdl_shift = {mdl_shift[EB-2:0], b};
        #250;
        ser_clk = 1'b0;
        #150;
    endtask

    task automatic send_word(input logic [EB-1:0] w);
        for (int i = EB - 1; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic pulse_latch();
        #100;
        ser_latch = 1'b1;
        if (ser_clr_n) mdl_store = mdl_shift;
        #250;
        ser_latch = 1'b0;
        #250;
    endtask

    task automatic set_clr(input logic v);
        ser_clr_n = v;
        if (!v) mdl_store = '0;
        #200;
    endtask

    initial begin
        rst_n = 1'b0;
        mode_serial = 1'b1; ser_clk = 1'b0; ser_data = 1'b0; ser_clr_n = 1'b0;
        ser_latch = 1'b0; gate_en = 1'b0; stby_n = 1'b0; par_in = '0;
        #103;
        rst_n = 1'b1;
        #40;
        check("R1 reset all off", 8'h00);

        stby_n = 1'b1; gate_en = 1'b1;
        set_clr(1'b1);
        check("R7 empty storage applied", 8'h00);

        send_word(8'hA5);
        pulse_latch();
        check("R2 R6 word A5 mapped", 8'hA5);

        // clear with a concurrent latch; clocks while clear low do not shift
        set_clr(1'b0);
        check("R5 clear empties storage", 8'h00);
        pulse_latch();
        check("R5 clear wins over latch", 8'h00);
        send_word(8'h3C);
        set_clr(1'b1);
        check("R5 storage stays empty after clear", 8'h00);
        pulse_latch();
        check("R3 R5 shift kept across clear", 8'hA5);

        send_word(8'h0F);
        #200;
        check("R4 storage holds without latch", 8'hA5);
        pulse_latch();
        check("R4 latch copies 0F", 8'h0F);

        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        pulse_latch();
        check("R2 partial shift gives 7D", 8'h7D);

        gate_en = 1'b0; #200;
        check("R7 gate low all off", 8'h00);
        gate_en = 1'b1; #200;
        check("R7 gate high restores", 8'h7D);

        stby_n = 1'b0; #200;
        check("R8 standby serial off", 8'h00);
        mode_serial = 1'b0; par_in = 8'hFF; #200;
        check("R8 standby parallel off", 8'h00);
        stby_n = 1'b1; mode_serial = 1'b1; #200;
        check("R8 storage survives standby", 8'h7D);

        mode_serial = 1'b0; par_in = 8'h96; gate_en = 1'b0; #200;
        check("R9 parallel passthrough gate ignored", 8'h96);
        send_word(8'hC3);
        pulse_latch();
        check("R9 serial load hidden in parallel", 8'h96);
        gate_en = 1'b1; mode_serial = 1'b1; #200;
        check("R9 loaded word shows in serial", 8'hC3);

        mode_serial = 1'b0; #200;
        par_in = 8'h5A; #80;
        check("R10 change within four cycles", 8'h5A);

        void'($urandom(32'h0000_2A17));
        for (int it = 0; it < 24; it++) begin
            logic [EB-1:0] w;
            w = EB'($urandom());
            mode_serial = 1'($urandom());
            if (($urandom() & 7) == 0) set_clr(1'b0);
            send_word(w);
            set_clr(1'b1);
            if (($urandom() & 3) != 0) pulse_latch();
            stby_n  = (($urandom() & 7) != 0);
            gate_en = (($urandom() & 3) != 0);
            mode_serial = (($urandom() & 3) != 0);
            par_in  = EB'($urandom());
            #200;
            check_model("R2 R4 R6 R7 R8 R9 random");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: en_out=%02h expected=completion", en_out);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule